// File: doc/BRIEF.md
# Dual Interval Timer

This block holds two identical 16-bit interval timers behind a small byte-wide register window. A shared prescaler divides the system clock down to a 2 MHz count enable. On every enable cycle each timer's counter steps down by one. When a counter is already at zero on an enable cycle, it takes a fresh value from that timer's reload register and raises a one-cycle interrupt pulse. It then keeps counting down from the new value.

Software writes the reload value one byte at a time. A write to a strobe address starts the timer: the counter takes the reload value at once. A write to the other strobe address freezes a copy of the live count in a snapshot register. The snapshot's two bytes can then be read at leisure while the counter keeps moving, so the two halves of a 16-bit read always belong together.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset all counters, reload registers and snapshot registers are zero, both interrupt outputs are low, and every read address returns 0.
- R2: The count enable fires once every PRESCALE_DIV system clocks. The first one falls on the PRESCALE_DIV-th rising edge after reset is released. Apart from a start command, counters change only on enable edges.
- R3: On an enable edge where a counter is not zero and no start command is present, that counter decreases by exactly one.
- R4: On an enable edge where a counter is zero and no start command is present, the counter loads its reload value. The matching `irq` bit is then high for exactly one clock after that edge. A reload value of 0 therefore gives one pulse on every enable edge.
- R5: `bus_addr[2]` selects the timer (0 or 1). `bus_addr[1:0]` selects the register: 0 is the low byte and 1 is the high byte. A write to 0 or 1 changes only that byte of the reload register and leaves the running counter untouched.
- R6: A write to offset 2 (start) loads the counter from the reload register on that edge, whatever the data. If it lands on an enable edge, the start wins: there is no decrement and no interrupt pulse.
- R7: A write to offset 3 (snapshot) copies the counter value held just before that edge into the snapshot register. This holds even on an enable edge. Reads of offsets 0 and 1 return the snapshot's low and high bytes, which stay unchanged until the next snapshot.
- R8: Reads of offsets 2 and 3 return 0.
- R9: The two timers are independent: commands and reloads of one never alter the other's counter, snapshot or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address: timer select and register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 2 | One-cycle interrupt pulse per timer on reload at zero |

## Verification
Two pairs of functions can fall in the same clock: a start command on the enable edge where the counter sits at zero, and a snapshot command on any enable edge. The bench keeps its own count of rising edges since reset release. From that count it places a write so that it lands exactly on an enable edge. For the start collision it expects the reload value with no interrupt pulse, and then the reload value minus one after the next enable. For the snapshot collision it expects the value read just before that edge, and one less on a snapshot taken right after.

// File: rtl/dit_pkg.sv
`timescale 1ns/1ps
package dit_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    REG_LO    = 2'd0,
    REG_HI    = 2'd1,
    REG_START = 2'd2,
    REG_SNAP  = 2'd3
  } reg_sel_e;

  // Next counter value: start beats everything, otherwise step or reload on enable
  function automatic logic [CNT_W-1:0] dit_next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rel,
    input logic             en,
    input logic             start
  );
    if (start)       return rel;
    if (!en)         return cur;
    if (cur == '0)   return rel;
    return cur - 1'b1;
  endfunction

  // Replace one byte lane of a word
  function automatic logic [CNT_W-1:0] dit_put_byte(
    input logic [CNT_W-1:0]  word,
    input logic              upper,
    input logic [BYTE_W-1:0] b
  );
    logic [CNT_W-1:0] r;
    r = word;
    if (upper) r[CNT_W-1:BYTE_W] = b;
    else       r[BYTE_W-1:0]     = b;
    return r;
  endfunction
endpackage

// File: rtl/dit_prescaler.sv
`timescale 1ns/1ps
module dit_prescaler #(
  parameter int unsigned DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PW-1:0] cnt_q;
      assign tick_o = (cnt_q == PW'(DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dit_timer_core.sv
`timescale 1ns/1ps
module dit_timer_core
  import dit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              start_i,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  snap_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] count_q, reload_q, snap_q, count_d;
  logic             irq_q;

  // Named internal events
  logic zero_hit;
  logic step_en;
  assign zero_hit = tick_i && !start_i && (count_q == '0);
  assign step_en  = tick_i && !start_i && (count_q != '0);
  assign count_d  = dit_next_count(count_q, reload_q, tick_i, start_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      snap_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      if (wr_lo_i)      reload_q <= dit_put_byte(reload_q, 1'b0, wdata_i);
      else if (wr_hi_i) reload_q <= dit_put_byte(reload_q, 1'b1, wdata_i);
      if (snap_i)       snap_q   <= count_q;
      irq_q <= zero_hit;
    end
  end

  assign snap_o = snap_q;
  assign irq_o  = irq_q;

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !start_i) |=> $stable(count_q));
  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (count_q == $past(count_q) - 1'b1) && !irq_o);
  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(count_q) == '0) && (count_q == $past(reload_q)) && $past(tick_i));
  // R5
  lo_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> reload_q[CNT_W-1:BYTE_W] == $past(reload_q[CNT_W-1:BYTE_W]));
  // R6
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_q == $past(reload_q)) && !irq_o);
  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> snap_o == $past(count_q));
endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int unsigned NUM_TIMERS   = 2,
  parameter int unsigned PRESCALE_DIV = 25,
  localparam int unsigned SEL_W  = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int unsigned ADDR_W = SEL_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  logic             tick;
  reg_sel_e         reg_sel;
  logic [SEL_W-1:0] tmr_idx;
  logic [CNT_W-1:0] snap [NUM_TIMERS];

  assign reg_sel = reg_sel_e'(bus_addr[1:0]);
  assign tmr_idx = bus_addr[ADDR_W-1:2];

  dit_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic hit;
    assign hit = bus_wr && (tmr_idx == SEL_W'(t));

    dit_timer_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .wr_lo_i (hit && (reg_sel == REG_LO)),
      .wr_hi_i (hit && (reg_sel == REG_HI)),
      .start_i (hit && (reg_sel == REG_START)),
      .snap_i  (hit && (reg_sel == REG_SNAP)),
      .wdata_i (bus_wdata),
      .snap_o  (snap[t]),
      .irq_o   (irq[t])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(tmr_idx) < int'(NUM_TIMERS)) begin
      case (reg_sel)
        REG_LO:  bus_rdata = snap[tmr_idx][BYTE_W-1:0];
        REG_HI:  bus_rdata = snap[tmr_idx][CNT_W-1:BYTE_W];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R8
  strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[1] |-> bus_rdata == '0);
endmodule

// File: tb/dual_interval_timer_tb.sv
`timescale 1ns/1ps
module dual_interval_timer_tb;
  localparam int unsigned DIV = 25;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] irq;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dual_interval_timer #(.NUM_TIMERS(2), .PRESCALE_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] base, output int v);
    logic [7:0] lo;
    bus_addr = base; #1 lo = bus_rdata;
    bus_addr = base | 3'd1; #1 v = {bus_rdata, lo};
  endtask

  // Return at the falling edge right after an enable edge
  task automatic wait_tick();
    do @(negedge clk); while (cyc % DIV != 0);
  endtask

  // Return at the falling edge right before an enable edge
  task automatic wait_pre_tick();
    do @(negedge clk); while (cyc % DIV != DIV - 1);
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk);
    check("R1 irq after reset", int'(irq), 0);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a); #1;
      check("R1 read after reset", int'(bus_rdata), 0);
    end
  endtask

  task automatic t_zero_reload();
    wait_tick();
    check("R2/R4 first enable at edge DIV, zero reload pulses", int'(irq), 3);
    @(negedge clk);
    check("R4 pulse one cycle wide", int'(irq), 0);
    wait_tick();
    check("R4 zero reload pulses every enable", int'(irq), 3);
  endtask

  task automatic t_start_count();
    int v;
    wait_tick();
    wr(3'd0, 8'hE8);
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h5A);
    repeat (3) wait_tick();
    wr(3'd3, 8'h00);
    rd16(3'd0, v);
    check("R3/R6 start then three steps", v, 997);
    repeat (2) wait_tick();
    rd16(3'd0, v);
    check("R7 snapshot held while counting", v, 997);
    wr(3'd3, 8'h00);
    rd16(3'd0, v);
    check("R3 two further steps", v, 995);
    wr(3'd0, 8'h05);
    wr(3'd3, 8'h00);
    rd16(3'd0, v);
    check("R5 byte write leaves counter alone", v, 995);
  endtask

  task automatic t_reload_at_zero();
    int v;
    wait_tick();
    wr(3'd4, 8'd2);
    wr(3'd5, 8'd0);
    wr(3'd6, 8'd0);
    wait_tick();
    check("R4 no pulse at count 1", int'(irq[1]), 0);
    wait_tick();
    check("R4 no pulse on reaching 0", int'(irq[1]), 0);
    wait_tick();
    check("R4 pulse on reload", int'(irq[1]), 1);
    check("R9 other timer quiet", int'(irq[0]), 0);
    wr(3'd7, 8'd0);
    rd16(3'd4, v);
    check("R4 counter reloaded", v, 2);
    rd16(3'd0, v);
    check("R9 timer0 snapshot kept", v, 995);
  endtask

  task automatic t_start_on_zero();
    int v;
    wait_tick();
    wr(3'd4, 8'd1);
    wr(3'd6, 8'd0);
    wait_tick();
    wr(3'd4, 8'd7);
    wait_pre_tick();
    wr(3'd6, 8'hFF);
    check("R6 start on zero enable edge gives no pulse", int'(irq[1]), 0);
    wait_tick();
    wr(3'd7, 8'd0);
    rd16(3'd4, v);
    check("R6 start won over reload/step", v, 6);
  endtask

  task automatic t_snap_on_tick();
    int x, v;
    wait_tick();
    wr(3'd3, 8'd0);
    rd16(3'd0, x);
    wait_pre_tick();
    wr(3'd3, 8'd0);
    rd16(3'd0, v);
    check("R7 snapshot on enable edge takes prior value", v, x);
    wr(3'd3, 8'd0);
    rd16(3'd0, v);
    check("R7 snapshot after enable edge", v, x - 1);
  endtask

  task automatic t_strobe_reads();
    bus_addr = 3'd2; #1 check("R8 start address reads 0", int'(bus_rdata), 0);
    bus_addr = 3'd3; #1 check("R8 snapshot address reads 0", int'(bus_rdata), 0);
    bus_addr = 3'd6; #1 check("R8 start address reads 0", int'(bus_rdata), 0);
    bus_addr = 3'd7; #1 check("R8 snapshot address reads 0", int'(bus_rdata), 0);
  endtask

  task automatic t_zero_rate();
    wait_tick();
    wr(3'd0, 8'd0);
    wr(3'd1, 8'd0);
    wr(3'd2, 8'd0);
    wait_tick();
    check("R4 zero reload after start pulses", int'(irq[0]), 1);
    @(negedge clk);
    check("R4 pulse ends", int'(irq[0]), 0);
    wait_tick();
    check("R4 pulse at every enable", int'(irq[0]), 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_reload();
    t_start_count();
    t_reload_at_zero();
    t_start_on_zero();
    t_snap_on_tick();
    t_strobe_reads();
    t_zero_rate();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule